// File: doc/BRIEF.md
# Function Power-State Change Handshake

This block sits beside a configuration responder and follows configuration writes to the power management control field of each function. A write that puts a function into a sleep state (D1 or D3hot) is not applied at once. The block raises an interrupt toward user logic and shows the number of the affected function. It holds back every configuration completion until the user acknowledges. Only then does the new state become visible on the per-function state outputs. Writes that request D0 or D2 take effect at once, with no interrupt and no stall.

Two physical functions and six virtual functions are tracked. They are numbered 0–1 for the physical functions and 2–7 for virtual functions 0–5. While one sleep request waits for its acknowledge, one more sleep request can be parked behind it. That parked request becomes current right after the acknowledge. User logic that never needs to delay completions can tie the acknowledge high. A sleep request then commits in the cycle it arrives, with no interrupt and no hold.

Top module: `pm_dstate_handshake`

## Requirements
- R1: Power states use the 2-bit code D0=00, D1=01, D2=10, D3hot=11. The interrupt `psc_irq` rises only after a write (`cfg_wr_valid`=1) with function number below 8 and state code 01 or 11. It is high in the cycle that follows the write edge.
- R2: Once high, `psc_irq` stays high on every cycle until `user_ack` is sampled high. If nothing is queued, it is low in the cycle after that edge.
- R3: `cpl_hold` equals `psc_irq`. `cpl_grant` is `cpl_req` in the same cycle when `cpl_hold` is low, and 0 when it is high.
- R4: While `psc_irq` is high, `psc_func` carries the number of the function whose sleep request is pending. When idle, it reads 0.
- R5: A pending sleep state is not shown until it is acknowledged. After the acknowledge edge it appears on the outputs. Function i (0–1) is at `pf_state[2i+1:2i]`. Function 2+j is at `vf_state[2j+1:2j]`.
- R6: A write with code 00 or 10 to a valid function updates that function's state on the next cycle. It raises no interrupt.
- R7: When idle, a sleep write that arrives together with `user_ack`=1 commits directly: the state shows next cycle and `psc_irq` stays low.
- R8: While a request is pending, one further sleep write is queued. After the acknowledge it becomes pending, with `psc_irq` still high and `psc_func` showing its number. A sleep write that arrives while the queue is full is ignored.
- R9: Writes with function number 8 or higher change no state and raise no interrupt.
- R10: Synchronous reset sets every function to D0, clears the interrupt and any queued request, and sets `psc_func` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_valid | input | 1 | Power-control configuration write strobe |
| cfg_wr_func | input | 8 | Target function number of the write |
| cfg_wr_state | input | 2 | Requested power state code |
| cpl_req | input | 1 | Responder has a completion ready to return |
| user_ack | input | 1 | User acknowledge of the pending state change |
| psc_irq | output | 1 | Power-state change interrupt |
| psc_func | output | 8 | Function number of the pending change |
| cpl_hold | output | 1 | Completions are being held |
| cpl_grant | output | 1 | Completion may be returned this cycle |
| pf_state | output | 4 | Current states of physical functions 0–1 |
| vf_state | output | 12 | Current states of virtual functions 0–5 |

## Verification
Every function number is swept against all four state codes, one write at a time, with the acknowledge low. This separates sleep codes from immediate codes and shows that the correct output field changes, and only after the acknowledge. A burst of three sleep writes without an acknowledge then separates the pending slot, the one-entry queue and the dropped third write. Writes to reserved function numbers and a write made with the acknowledge already high cover the ignore path and the direct-commit path. A second reset checks that committed states return to D0.

// File: rtl/pm_hs_pkg.sv
package pm_hs_pkg;
  localparam int PM_FN_W = 8;
  localparam int PM_PS_W = 2;

  typedef enum logic [PM_PS_W-1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_t;

  typedef struct packed {
    logic [PM_FN_W-1:0] fn;
    pstate_t            st;
  } pm_req_t;
endpackage

// File: rtl/pm_wr_classify.sv
module pm_wr_classify
  import pm_hs_pkg::*;
#(
  parameter int NUM_FN = 8
) (
  input  logic               wr_valid,
  input  logic [PM_FN_W-1:0] wr_func,
  input  pstate_t            wr_state,
  output logic               sleep_v,
  output logic               imm_v,
  output pm_req_t            req
);
  logic fn_ok;

  always_comb begin
    fn_ok   = wr_func < PM_FN_W'(NUM_FN);
    req.fn  = wr_func;
    req.st  = wr_state;
    // D1 and D3hot both carry bit 0 set; those need a handshake
    sleep_v = wr_valid && fn_ok && wr_state[0];
    imm_v   = wr_valid && fn_ok && !wr_state[0];
  end
endmodule

// File: rtl/pm_req_queue.sv
module pm_req_queue
  import pm_hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sleep_v,
  input  pm_req_t sleep_req,
  input  logic    ack,
  output logic    pend_v,
  output pm_req_t pend,
  output logic    commit_v,
  output pm_req_t commit_req
);
  logic    q_v;
  pm_req_t q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend   <= '0;
      q_v    <= 1'b0;
      q      <= '0;
    end else if (pend_v && ack) begin
      if (q_v) begin
        pend <= q;
        q_v  <= sleep_v;
        if (sleep_v) q <= sleep_req;
      end else begin
        pend_v <= sleep_v;
        pend   <= sleep_v ? sleep_req : '0;
      end
    end else if (pend_v) begin
      if (sleep_v && !q_v) begin
        q_v <= 1'b1;
        q   <= sleep_req;
      end
    end else if (sleep_v && !ack) begin
      pend_v <= 1'b1;
      pend   <= sleep_req;
    end
  end

  always_comb begin
    commit_v   = ack && (pend_v || sleep_v);
    commit_req = pend_v ? pend : sleep_req;
  end

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    pend_v && !ack |=> pend_v); // R2
  AST_FUNC_STEADY: assert property (@(posedge clk) disable iff (rst)
    pend_v && !ack |=> $stable(pend)); // R4
  AST_QUEUE_BEHIND_PEND: assert property (@(posedge clk) disable iff (rst)
    q_v |-> pend_v); // R8
  AST_QUEUE_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    pend_v && ack && q_v |=> pend_v); // R8
endmodule

// File: rtl/pm_state_table.sv
module pm_state_table
  import pm_hs_pkg::*;
#(
  parameter int NUM_PF = 2,
  parameter int NUM_VF = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       commit_we,
  input  pm_req_t                    commit_req,
  input  logic                       imm_we,
  input  pm_req_t                    imm_req,
  output logic [NUM_PF*PM_PS_W-1:0]  pf_state,
  output logic [NUM_VF*PM_PS_W-1:0]  vf_state
);
  localparam int NUM_FN = NUM_PF + NUM_VF;

  logic [NUM_FN*PM_PS_W-1:0] st_flat;

  for (genvar i = 0; i < NUM_FN; i++) begin : g_fn
    pstate_t st_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q <= PS_D0;
      end else if (imm_we && imm_req.fn == PM_FN_W'(i)) begin
        st_q <= imm_req.st;
      end else if (commit_we && commit_req.fn == PM_FN_W'(i)) begin
        st_q <= commit_req.st;
      end
    end
    assign st_flat[i*PM_PS_W +: PM_PS_W] = st_q;
  end

  assign pf_state = st_flat[NUM_PF*PM_PS_W-1:0];
  assign vf_state = st_flat[NUM_FN*PM_PS_W-1:NUM_PF*PM_PS_W];

  AST_STATE_KEPT: assert property (@(posedge clk) disable iff (rst)
    !commit_we && !imm_we |=> $stable(st_flat)); // R5
endmodule

// File: rtl/pm_dstate_handshake.sv
module pm_dstate_handshake
  import pm_hs_pkg::*;
#(
  parameter int NUM_PF = 2,
  parameter int NUM_VF = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr_valid,
  input  logic [7:0]                 cfg_wr_func,
  input  logic [1:0]                 cfg_wr_state,
  input  logic                       cpl_req,
  input  logic                       user_ack,
  output logic                       psc_irq,
  output logic [7:0]                 psc_func,
  output logic                       cpl_hold,
  output logic                       cpl_grant,
  output logic [NUM_PF*2-1:0]        pf_state,
  output logic [NUM_VF*2-1:0]        vf_state
);
  localparam int NUM_FN = NUM_PF + NUM_VF;

  logic    sleep_v, imm_v, pend_v, commit_v;
  pm_req_t wr_req, pend, commit_req;

  pm_wr_classify #(.NUM_FN(NUM_FN)) u_classify (
    .wr_valid (cfg_wr_valid),
    .wr_func  (cfg_wr_func),
    .wr_state (pstate_t'(cfg_wr_state)),
    .sleep_v  (sleep_v),
    .imm_v    (imm_v),
    .req      (wr_req)
  );

  pm_req_queue u_queue (
    .clk        (clk),
    .rst        (rst),
    .sleep_v    (sleep_v),
    .sleep_req  (wr_req),
    .ack        (user_ack),
    .pend_v     (pend_v),
    .pend       (pend),
    .commit_v   (commit_v),
    .commit_req (commit_req)
  );

  pm_state_table #(.NUM_PF(NUM_PF), .NUM_VF(NUM_VF)) u_table (
    .clk        (clk),
    .rst        (rst),
    .commit_we  (commit_v),
    .commit_req (commit_req),
    .imm_we     (imm_v),
    .imm_req    (wr_req),
    .pf_state   (pf_state),
    .vf_state   (vf_state)
  );

  always_comb begin
    psc_irq   = pend_v;
    psc_func  = pend.fn;
    cpl_hold  = pend_v;
    cpl_grant = cpl_req && !pend_v;
  end

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(psc_irq) |-> $past(cfg_wr_valid) && $past(cfg_wr_state[0])
                      && ($past(cfg_wr_func) < 8'(NUM_FN))); // R1
  AST_COMMIT_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    commit_v |-> user_ack); // R5
  AST_NO_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
    psc_irq |-> !cpl_grant); // R3
  AST_IDLE_FUNC_ZERO: assert property (@(posedge clk) disable iff (rst)
    !psc_irq |-> psc_func == 8'd0); // R4
endmodule

// File: tb/pm_dstate_handshake_test.sv
module pm_dstate_handshake_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_valid = 1'b0;
  logic [7:0] cfg_wr_func = '0;
  logic [1:0] cfg_wr_state = '0;
  logic       cpl_req = 1'b1;
  logic       user_ack = 1'b0;
  logic       psc_irq, cpl_hold, cpl_grant;
  logic [7:0] psc_func;
  logic [3:0] pf_state;
  logic [11:0] vf_state;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int exp_st [8];

  pm_dstate_handshake uut (
    .clk(clk), .rst(rst), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_func(cfg_wr_func),
    .cfg_wr_state(cfg_wr_state), .cpl_req(cpl_req), .user_ack(user_ack),
    .psc_irq(psc_irq), .psc_func(psc_func), .cpl_hold(cpl_hold),
    .cpl_grant(cpl_grant), .pf_state(pf_state), .vf_state(vf_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int actual, int expected);
    n_cmp++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  function automatic int fn_state(int i);
    if (i < 2) return int'(pf_state[2*i +: 2]);
    return int'(vf_state[2*(i-2) +: 2]);
  endfunction

  task automatic check_all_states(string req);
    for (int i = 0; i < 8; i++) check(req, fn_state(i), exp_st[i]);
  endtask

  task automatic do_write(int f, int s, bit ack);
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_func = 8'(f); cfg_wr_state = 2'(s); user_ack = ack;
    @(negedge clk);
    cfg_wr_valid = 1'b0; user_ack = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); user_ack = 1'b1;
    @(negedge clk); user_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_st[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 irq", psc_irq, 0);
    check("R10 func", psc_func, 0);
    check_all_states("R10 state");

    // Sweep: every function against every code
    for (int f = 0; f < 8; f++) begin
      for (int s = 0; s < 4; s++) begin
        do_write(f, s, 1'b0);
        if (s % 2 == 1) begin
          check("R1 irq raised", psc_irq, 1);
          check("R4 func", psc_func, f);
          check("R3 hold", cpl_hold, 1);
          check("R3 grant blocked", cpl_grant, 0);
          check("R5 not yet", fn_state(f), exp_st[f]);
          repeat (3) @(negedge clk);
          check("R2 irq held", psc_irq, 1);
          pulse_ack();
          exp_st[f] = s;
          check("R2 irq cleared", psc_irq, 0);
          check("R4 idle func", psc_func, 0);
          check("R3 grant", cpl_grant, 1);
          check_all_states("R5 committed");
        end else begin
          exp_st[f] = s;
          check("R6 no irq", psc_irq, 0);
          check_all_states("R6 immediate");
        end
      end
    end

    // Queue: pending, one queued, third dropped
    do_write(3, 3, 1'b0);
    do_write(0, 2, 1'b0); exp_st[0] = 2;   // immediate during pending
    check("R6 imm while pending", fn_state(0), 2);
    do_write(5, 1, 1'b0);
    do_write(6, 1, 1'b0);
    check("R8 head func", psc_func, 3);
    pulse_ack();
    exp_st[3] = 3;
    check("R8 irq stays", psc_irq, 1);
    check("R8 queued func", psc_func, 5);
    check_all_states("R8 after first ack");
    pulse_ack();
    exp_st[5] = 1;
    check("R8 irq done", psc_irq, 0);
    check_all_states("R8 dropped write ignored");
    repeat (2) @(negedge clk);
    check("R8 nothing left", psc_irq, 0);

    // Reserved function numbers
    do_write(8, 3, 1'b0);
    do_write(200, 1, 1'b0);
    do_write(255, 0, 1'b0);
    check("R9 no irq", psc_irq, 0);
    check_all_states("R9 no change");

    // Direct commit with ack held high
    @(negedge clk); user_ack = 1'b1;
    cfg_wr_valid = 1'b1; cfg_wr_func = 8'd7; cfg_wr_state = 2'd3;
    @(negedge clk); cfg_wr_valid = 1'b0;
    exp_st[7] = 3;
    check("R7 no irq", psc_irq, 0);
    check("R7 grant", cpl_grant, 1);
    check_all_states("R7 state");
    cfg_wr_valid = 1'b1; cfg_wr_func = 8'd1; cfg_wr_state = 2'd1;
    @(negedge clk); cfg_wr_valid = 1'b0; user_ack = 1'b0;
    exp_st[1] = 1;
    check("R7 no irq 2", psc_irq, 0);
    check_all_states("R7 state 2");

    // Reset clears pending and states
    do_write(2, 3, 1'b0);
    check("R1 irq before reset", psc_irq, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) exp_st[i] = 0;
    check("R10 irq cleared", psc_irq, 0);
    check("R10 func cleared", psc_func, 0);
    check_all_states("R10 states D0");

    finish_run();
  end
endmodule